// File: doc/BRIEF.md
# Slow-Clock Frequency Calibration Counter

This block measures how fast a low-frequency clock runs, using a fast reference clock as the ruler. Software picks one of four slow sources, sets how many slow periods to observe, and sets a guard limit in reference cycles. A rising edge on the start input launches the measurement. The block then counts reference cycles until the chosen number of slow rising edges has been seen. It reports that count with a ready flag. If the guard limit is reached first, it reports a timeout flag instead.

The selected slow clock crosses into the reference domain through a two-flop synchronizer. Its rising edges are detected there, so all logic runs on the reference clock alone. Software turns the count into a period or a frequency. The usual guard settings are the slow-cycle target shifted left by 12 for the crystal and the divided-RC sources, and shifted left by 10 for the faster internal oscillator. A measurement that is already running can be cut short by lowering the guard to 1.

The count and both flags are plain status levels. They hold their values until the next start edge, so the interface has no valid/ready handshake and no back-pressure.

Top module: `slow_cal_counter`

## Requirements
- R1: While reset is low and on the first cycle after reset, `cal_ready`, `cal_timeout` and `cal_busy` are 0 and `cal_count` is 0.
- R2: `src_sel` picks bit `src_sel` of `slow_clk_i`. Code 0 is the currently muxed slow clock, 1 is the RC oscillator divided by 256, 2 is the external 32 kHz crystal and 3 is the internal oscillator. Only the selected bit affects the count.
- R3: A measurement starts only on a reference edge where `start` is 1 and was 0 at the previous edge. Holding `start` high does not start another run. `cal_busy` is 1 from that edge until the run ends.
- R4: The start edge is edge 0. A slow rising edge first sampled at reference edge m is consumed at edge m+2, and only edges with m ≥ −1 count. The run completes at the edge that consumes the N-th such slow edge. At that edge `cal_ready` rises, `cal_busy` falls, and `cal_count` equals that edge's number.
- R5: If the running reference count reaches `timeout_thr` before completion, `cal_timeout` rises, `cal_count` becomes 0 and `cal_busy` falls, at edge max(`timeout_thr`,1). If completion and the limit fall on the same edge, completion wins.
- R6: A timed-out run leaves no residue, so the next run with the same settings gives the same result as a run with no earlier timeout.
- R7: If `timeout_thr` is lowered to 1 during a run, the run times out at the next reference edge.
- R8: A start edge clears `cal_ready` and `cal_timeout` and begins a fresh run, even when a run is already in progress.
- R9: While idle, `cal_count`, `cal_ready` and `cal_timeout` hold their values.
- R10: A `slow_target` of 0 behaves as a target of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| slow_clk_i | input | 4 | Slow clock sources, indexed by source code |
| src_sel | input | 2 | Slow source code |
| start | input | 1 | Launch; acts on its rising edge |
| slow_target | input | 16 | Number of slow periods to measure |
| timeout_thr | input | 32 | Guard limit in reference cycles, compared live |
| cal_count | output | 32 | Measured reference-cycle count |
| cal_ready | output | 1 | Measurement completed |
| cal_timeout | output | 1 | Guard limit reached first |
| cal_busy | output | 1 | Measurement in progress |

## Verification
A stale reference or slow counter shows up at the first completion after a start edge. The count, or the edge on which the flag rises, is then off from the value worked out from the slow clock's phase, so each run is checked on both the value and the exact cycle. A synchronizer that is too short or too long moves every completion by whole reference cycles. A timeout path that does not clear its state shows up in the very next run. Flags that fail to clear, or that start again from a held start level, show up one cycle after the start edge, or as a result that no run asked for.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic {
    CAL_IDLE = 1'b0,
    CAL_RUN  = 1'b1
  } cal_state_e;

  typedef enum logic [1:0] {
    SRC_MUXED  = 2'd0,
    SRC_RC_256 = 2'd1,
    SRC_XTAL32 = 2'd2,
    SRC_INTOSC = 2'd3
  } cal_src_e;
endpackage

// File: rtl/cal_src_sync.sv
module cal_src_sync #(
  parameter int NSRC   = 4,
  parameter int STAGES = 2,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  slow_i,
  input  logic [SEL_W-1:0] sel,
  output logic             rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe;
  logic            picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) picked = slow_i[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[0] <= 1'b0;
          else        pipe[0] <= picked;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[g] <= 1'b0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/cal_start_det.sv
module cal_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic kick_o
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start;
  end

  assign kick_o = start & ~start_q;
endmodule

// File: rtl/cal_core.sv
module cal_core
  import cal_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             slow_rise,
  input  logic [TGT_W-1:0] target,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o,
  output logic             timeout_o,
  output logic             busy_o
);
  cal_state_e       state;
  logic [CNT_W-1:0] ref_cnt;
  logic [TGT_W-1:0] slow_cnt;
  logic [CNT_W-1:0] ref_nxt;
  logic [TGT_W:0]   slow_nxt;
  logic [TGT_W:0]   tgt_eff;
  logic             done;
  logic             limit_hit;

  always_comb begin
    ref_nxt   = ref_cnt + 1'b1;
    slow_nxt  = {1'b0, slow_cnt} + 1'b1;
    tgt_eff   = (target == '0) ? (TGT_W+1)'(1) : {1'b0, target};
    done      = slow_rise && (slow_nxt >= tgt_eff);
    limit_hit = (ref_nxt >= thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= CAL_IDLE;
      ref_cnt   <= '0;
      slow_cnt  <= '0;
      count_o   <= '0;
      ready_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else if (kick) begin
      state     <= CAL_RUN;
      ref_cnt   <= '0;
      slow_cnt  <= '0;
      ready_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else if (state == CAL_RUN) begin
      ref_cnt <= ref_nxt;
      if (slow_rise) slow_cnt <= slow_nxt[TGT_W-1:0];
      if (done) begin
        count_o <= ref_nxt;
        ready_o <= 1'b1;
        state   <= CAL_IDLE;
      end else if (limit_hit) begin
        count_o   <= '0;
        timeout_o <= 1'b1;
        state     <= CAL_IDLE;
      end
    end
  end

  assign busy_o = (state == CAL_RUN);
endmodule

// File: rtl/slow_cal_counter.sv
module slow_cal_counter #(
  parameter int NSRC   = 4,
  parameter int STAGES = 2,
  parameter int CNT_W  = 32,
  parameter int TGT_W  = 16,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  slow_clk_i,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             start,
  input  logic [TGT_W-1:0] slow_target,
  input  logic [CNT_W-1:0] timeout_thr,
  output logic [CNT_W-1:0] cal_count,
  output logic             cal_ready,
  output logic             cal_timeout,
  output logic             cal_busy
);
  logic slow_rise;
  logic kick;

  cal_src_sync #(.NSRC(NSRC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .slow_i(slow_clk_i), .sel(src_sel), .rise_o(slow_rise)
  );

  cal_start_det u_start (
    .clk(clk), .rst_n(rst_n), .start(start), .kick_o(kick)
  );

  cal_core #(.CNT_W(CNT_W), .TGT_W(TGT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .kick(kick), .slow_rise(slow_rise),
    .target(slow_target), .thr(timeout_thr),
    .count_o(cal_count), .ready_o(cal_ready), .timeout_o(cal_timeout), .busy_o(cal_busy)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] timeout_thr,
  input logic [CNT_W-1:0] cal_count,
  input logic             cal_ready,
  input logic             cal_timeout,
  input logic             cal_busy
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_ready && cal_timeout)); // R5

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |=> (!cal_ready && !cal_timeout && cal_busy)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_ready) |-> !cal_busy); // R4

  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_timeout) |-> (cal_count == '0 && !cal_busy)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && !$past(cal_busy)) |-> ($stable(cal_count) && $stable(cal_ready) && $stable(cal_timeout))); // R9

  AST_ABORT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && timeout_thr == CNT_W'(1) && !$rose(start)) |=> !cal_busy); // R7
endmodule

bind slow_cal_counter cal_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .timeout_thr(timeout_thr),
  .cal_count(cal_count), .cal_ready(cal_ready), .cal_timeout(cal_timeout), .cal_busy(cal_busy)
);

// File: tb/sim_slow_cal_counter.sv
module sim_slow_cal_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  slow = 4'b0;
  logic [1:0]  sel = 2'd0;
  logic        start = 1'b0;
  logic [15:0] target = 16'd1;
  logic [31:0] thr = 32'hFFFF_FFFF;
  logic [31:0] cnt;
  logic        rdy, tmo, busy;

  always #10 clk = ~clk;  // 50 MHz

  slow_cal_counter u0 (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow), .src_sel(sel), .start(start),
    .slow_target(target), .timeout_thr(thr),
    .cal_count(cnt), .cal_ready(rdy), .cal_timeout(tmo), .cal_busy(busy)
  );

  int    PER [0:3] = '{6, 10, 14, 4};
  int    OFF [0:3] = '{0, 3, 5, 1};
  longint cyc = 0;
  int    n_chk = 0, n_bad = 0;
  bit    finished = 1'b0;

  typedef struct { bit is_tmo; longint res; longint edge_no; string req; } item_t;
  item_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  // slow source k rises just before reference edge m when (m+OFF)%PER == 0
  always @(negedge clk)
    for (int i = 0; i < 4; i++)
      slow[i] <= (((cyc + 1 + OFF[i]) % PER[i]) < (PER[i] / 2));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint calc_exp(input int s, input int tgt, input longint e0);
    longint base, r, first;
    int t;
    t = (tgt == 0) ? 1 : tgt;
    base = e0 - 1;
    r = (base + OFF[s]) % PER[s];
    first = base + ((r == 0) ? 0 : (PER[s] - r));
    return first + longint'(t - 1) * PER[s] + 2 - e0;
  endfunction

  // scoreboard monitor
  bit rdy_p = 1'b0, tmo_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ((rdy && !rdy_p) || (tmo && !tmo_p))) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3 unexpected result", cyc, -1);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(tmo == it.is_tmo, {it.req, " timeout flag"}, tmo, it.is_tmo);
        chk(rdy == !it.is_tmo, {it.req, " ready flag"}, rdy, !it.is_tmo);
        chk(cnt == it.res, {it.req, " count"}, cnt, it.res);
        chk(cyc == it.edge_no, {it.req, " edge"}, cyc, it.edge_no);
      end
    end
    rdy_p <= rdy;
    tmo_p <= tmo;
  end

  // setup, start edge, push expectation; thr = exp + rel when use_rel
  task automatic run_meas(input int s, input int tgt, input bit use_rel, input longint thr_v,
                          input string req, output longint e0);
    longint ex, th;
    item_t it;
    @(negedge clk);
    start = 1'b0; sel = 2'(s); target = 16'(tgt);
    repeat (3) @(negedge clk);
    e0 = cyc + 1;
    ex = calc_exp(s, tgt, e0);
    th = use_rel ? ex + thr_v : thr_v;
    thr = 32'(th);
    start = 1'b1;
    it.req = req;
    if (th < ex) begin
      it.is_tmo = 1'b1; it.res = 0; it.edge_no = e0 + ((th < 1) ? 1 : th);
    end else begin
      it.is_tmo = 1'b0; it.res = ex; it.edge_no = e0 + ex;
    end
    sb.push_back(it);
    @(negedge clk);
    chk(!rdy && !tmo && busy, "R8 flags clear, busy set on start", {rdy, tmo, busy}, 3'b001);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    longint e0, e1;
    item_t it;
    repeat (3) @(negedge clk);
    chk(cnt == 0 && !rdy && !tmo && !busy, "R1 in reset", {rdy, tmo, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnt == 0 && !rdy && !tmo && !busy, "R1 after reset", cnt, 0);

    // R2/R4: every source, several targets
    run_meas(0, 3, 1'b0, 32'hFFFF_FFFF, "R2 R4 src0", e0); drain();
    run_meas(1, 5, 1'b0, 32'hFFFF_FFFF, "R2 R4 src1", e0); drain();
    run_meas(2, 16, 1'b0, 32'hFFFF_FFFF, "R2 R4 src2", e0); drain();
    run_meas(3, 1, 1'b0, 32'hFFFF_FFFF, "R2 R4 src3", e0); drain();
    run_meas(3, 7, 1'b0, 32'hFFFF_FFFF, "R4 src3 t7", e0); drain();

    // R3/R9: start held high, nothing restarts, outputs hold
    repeat (40) @(negedge clk);
    chk(!busy && rdy && cnt == calc_exp(3, 7, e0), "R3 R9 held start no rerun", cnt, calc_exp(3, 7, e0));

    // R10: target zero acts as one
    run_meas(1, 0, 1'b0, 32'hFFFF_FFFF, "R10 target zero", e0); drain();

    // R5: timeout, threshold zero, tie goes to ready
    run_meas(1, 5, 1'b0, 20, "R5 timeout", e0); drain();
    repeat (30) @(negedge clk);
    chk(tmo && !rdy && cnt == 0, "R9 timeout holds", cnt, 0);
    run_meas(2, 4, 1'b0, 0, "R5 thr zero", e0); drain();
    run_meas(0, 6, 1'b1, 0, "R5 tie ready wins", e0); drain();
    run_meas(0, 6, 1'b1, -1, "R5 one short", e0); drain();

    // R6: same settings after a timeout
    run_meas(1, 5, 1'b0, 32'hFFFF_FFFF, "R6 after timeout", e0); drain();

    // R7: abort by lowering the threshold to 1
    run_meas(3, 16, 1'b0, 32'hFFFF_FFFF, "R7 abort", e0);
    void'(sb.pop_back());
    repeat (9) @(negedge clk);
    thr = 32'd1;
    it.is_tmo = 1'b1; it.res = 0; it.edge_no = cyc + 1; it.req = "R7 abort";
    sb.push_back(it);
    drain();

    // R8: restart while a run is in progress
    run_meas(2, 8, 1'b0, 32'hFFFF_FFFF, "R8 restart", e0);
    void'(sb.pop_back());
    repeat (5) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy, "R8 still running before restart", busy, 1);
    start = 1'b1;
    e1 = cyc + 1;
    it.is_tmo = 1'b0; it.res = calc_exp(2, 8, e1); it.edge_no = e1 + it.res; it.req = "R8 restart";
    sb.push_back(it);
    drain();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule